// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single transfer requests from inside a 16-bit processor into external bus cycles on a shared address/data bus with a 20-bit address space. One request carries a 20-bit address, a direction, a memory-or-I/O space select, an upper-byte flag, a two-bit segment code and, for writes, 16 bits of data. The sequencer then walks the cycle through T1, T2, T3, any number of wait states and T4.

The same sixteen lines carry the low address in T1 and data afterwards. Four upper lines carry the high address in T1 and then a status nibble that names the segment. A pulse marks the address phase so that external latches can capture it. Active-low read and write strobes, a space select and a direction select complete the bus. At the end of the cycle the block returns the captured read data together with a one-cycle completion strobe.

Between cycles another bus master may request the bus. The block then grants it and turns off all its pin drivers until the request is withdrawn. The bus pins are given as separate output, output-enable and input vectors, so the pad ring can form the bidirectional lines.

Top module: `mbus_seq`

## Requirements
- R1: In T1, `ad_o` carries address bits 15..0 with `ad_oe`=1, `ahs_o` carries address bits 19..16, `bhe_s7_n` is the inverse of `req_hi`, and `ale` is 1. `ale` is 0 in every other state.
- R2: From T2 through T4 (including wait states), `ahs_o[1:0]` carries the segment code (0 extra, 1 stack, 2 code or none, 3 data), `ahs_o[3:2]` is 0, and `bhe_s7_n` is 0.
- R3: In a read, `rd_n` is 0 in T2, T3 and every wait state and 1 elsewhere. `ad_oe` is 0 after T1, and `dt_r` is 0 for the whole cycle.
- R4: In a write, `wr_n` is 0 in T2, T3 and every wait state and 1 elsewhere. From T2 through T4, `ad_o` carries the write data with `ad_oe`=1, and `dt_r` is 1 for the whole cycle. `rd_n` and `wr_n` are never low together.
- R5: From T1 through T4, `m_io` equals the requested space (1 memory, 0 I/O).
- R6: `ready` is sampled on the edge that ends T3 and on the edge that ends each wait state. A low value adds one wait state with the strobe held active, so a cycle with n low samples lasts 4+n clocks.
- R7: Read data is taken from `ad_i` on the edge where `ready` is sampled high. `rsp_done` is 1 for exactly the T4 clock, for reads and writes alike, and `rsp_rdata` shows the captured word from T4 on.
- R8: `req_ready` is 1 only while idle with `hold` low. A request with `req_valid`=1 on such an edge starts T1 in the next clock.
- R9: `hold` is taken only when idle or in T4. `hlda` rises one clock later and stays 1 while `hold` stays high. During that time `ad_oe` and `ctl_oe` are 0 and requests are not accepted. `hlda` falls one clock after `hold` falls.
- R10: After reset the block is idle: `hlda`=0, `ale`=0, `rd_n`=`wr_n`=1, `rsp_done`=0, `ctl_oe`=1, `ad_oe`=0, `req_ready`=1 with `hold` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request is taken on this edge |
| req_addr | input | 20 | Transfer address |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| req_hi | input | 1 | Upper data byte takes part |
| req_seg | input | 2 | Segment code for the status lines |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock completion strobe (T4) |
| rsp_rdata | output | 16 | Captured read data |
| ready | input | 1 | Device can complete the transfer |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to another master |
| ad_o | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for ad_o |
| ad_i | input | 16 | Multiplexed address/data in |
| ahs_o | output | 4 | Upper address in T1, status after |
| bhe_s7_n | output | 1 | Upper-byte enable (active low) in T1, status bit 7 after |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | Space select |
| dt_r | output | 1 | Data direction, 1 when driving out |
| ctl_oe | output | 1 | Drive enable for all non-AD pins |

## Verification
Every pin is a registered state decode, so a request taken on an edge shows T1 pins one clock later. Status appears two clocks later, and T4 with its done strobe and read word appears 4+n clocks later for n low `ready` samples. A hold seen in idle or T4 gives `hlda` one clock later. The bench steps the cycle at falling edges and compares each phase with values its functions build from the request. It places the true read word on `ad_i` only in the clock where `ready` is high, so a capture on the wrong edge shows up. Hold is raised both in idle and in the middle of a cycle, to check that the grant waits for the cycle to end.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;
    localparam int MB_DW = 16;
    localparam int MB_AW = 20;
    localparam int MB_HW = MB_AW - MB_DW;
    localparam int MB_SW = 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HELD = 3'd6
    } mb_state_e;

    typedef struct packed {
        mb_state_e              st;
        logic [MB_AW-1:0]       addr;
        logic                   wr;
        logic                   mem;
        logic                   hi;
        logic [MB_SW-1:0]       seg;
        logic [MB_DW-1:0]       wdata;
        logic [MB_DW-1:0]       rdata;
    } mb_ctx_t;
endpackage

// File: rtl/mbus_ctrl.sv
`timescale 1ns/1ps
module mbus_ctrl
    import mbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [MB_AW-1:0]    req_addr,
    input  logic                req_write,
    input  logic                req_mem,
    input  logic                req_hi,
    input  logic [MB_SW-1:0]    req_seg,
    input  logic [MB_DW-1:0]    req_wdata,
    input  logic                ready,
    input  logic                hold,
    input  logic [MB_DW-1:0]    ad_i,
    output logic                req_ready,
    output mb_ctx_t             ctx
);
    mb_ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (hold) begin
                    ctx_d.st = ST_HELD;
                end else if (req_valid) begin
                    ctx_d.st    = ST_T1;
                    ctx_d.addr  = req_addr;
                    ctx_d.wr    = req_write;
                    ctx_d.mem   = req_mem;
                    ctx_d.hi    = req_hi;
                    ctx_d.seg   = req_seg;
                    ctx_d.wdata = req_wdata;
                end
            end
            ST_T1: ctx_d.st = ST_T2;
            ST_T2: ctx_d.st = ST_T3;
            ST_T3, ST_TW: begin
                if (ready) begin
                    ctx_d.st = ST_T4;
                    if (!ctx_q.wr) begin
                        ctx_d.rdata = ad_i;
                    end
                end else begin
                    ctx_d.st = ST_TW;
                end
            end
            ST_T4:   ctx_d.st = hold ? ST_HELD : ST_IDLE;
            ST_HELD: ctx_d.st = hold ? ST_HELD : ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign req_ready = (ctx_q.st == ST_IDLE) && !hold;
    assign ctx       = ctx_q;
endmodule

// File: rtl/mbus_pins.sv
`timescale 1ns/1ps
module mbus_pins
    import mbus_pkg::*;
(
    input  mb_ctx_t             ctx,
    output logic [MB_DW-1:0]    ad_o,
    output logic                ad_oe,
    output logic [MB_HW-1:0]    ahs_o,
    output logic                bhe_s7_n,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n,
    output logic                m_io,
    output logic                dt_r,
    output logic                ctl_oe,
    output logic                hlda,
    output logic                rsp_done
);
    logic in_cycle;
    logic strobe_phase;
    logic data_phase;

    always_comb begin
        in_cycle     = (ctx.st == ST_T1) || (ctx.st == ST_T2) || (ctx.st == ST_T3)
                    || (ctx.st == ST_TW) || (ctx.st == ST_T4);
        strobe_phase = (ctx.st == ST_T2) || (ctx.st == ST_T3) || (ctx.st == ST_TW);
        data_phase   = strobe_phase || (ctx.st == ST_T4);

        ad_o     = '0;
        ad_oe    = 1'b0;
        ahs_o    = '0;
        bhe_s7_n = 1'b1;
        ale      = 1'b0;
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        m_io     = 1'b1;
        dt_r     = 1'b0;
        ctl_oe   = 1'b1;
        hlda     = 1'b0;
        rsp_done = 1'b0;

        if (in_cycle) begin
            m_io = ctx.mem;
            dt_r = ctx.wr;
        end
        if (ctx.st == ST_T1) begin
            ad_o     = ctx.addr[MB_DW-1:0];
            ad_oe    = 1'b1;
            ahs_o    = ctx.addr[MB_AW-1:MB_DW];
            bhe_s7_n = ~ctx.hi;
            ale      = 1'b1;
        end
        if (data_phase) begin
            ahs_o    = {{(MB_HW-MB_SW){1'b0}}, ctx.seg};
            bhe_s7_n = 1'b0;
            if (ctx.wr) begin
                ad_o  = ctx.wdata;
                ad_oe = 1'b1;
            end
        end
        if (strobe_phase) begin
            rd_n = ctx.wr;
            wr_n = ~ctx.wr;
        end
        if (ctx.st == ST_T4) begin
            rsp_done = 1'b1;
        end
        if (ctx.st == ST_HELD) begin
            ctl_oe = 1'b0;
            hlda   = 1'b1;
        end
    end
endmodule

// File: rtl/mbus_seq.sv
`timescale 1ns/1ps
module mbus_seq
    import mbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [MB_AW-1:0]    req_addr,
    input  logic                req_write,
    input  logic                req_mem,
    input  logic                req_hi,
    input  logic [MB_SW-1:0]    req_seg,
    input  logic [MB_DW-1:0]    req_wdata,
    output logic                rsp_done,
    output logic [MB_DW-1:0]    rsp_rdata,
    input  logic                ready,
    input  logic                hold,
    output logic                hlda,
    output logic [MB_DW-1:0]    ad_o,
    output logic                ad_oe,
    input  logic [MB_DW-1:0]    ad_i,
    output logic [MB_HW-1:0]    ahs_o,
    output logic                bhe_s7_n,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n,
    output logic                m_io,
    output logic                dt_r,
    output logic                ctl_oe
);
    mb_ctx_t ctx;

    mbus_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_mem   (req_mem),
        .req_hi    (req_hi),
        .req_seg   (req_seg),
        .req_wdata (req_wdata),
        .ready     (ready),
        .hold      (hold),
        .ad_i      (ad_i),
        .req_ready (req_ready),
        .ctx       (ctx)
    );

    mbus_pins u_pins (
        .ctx      (ctx),
        .ad_o     (ad_o),
        .ad_oe    (ad_oe),
        .ahs_o    (ahs_o),
        .bhe_s7_n (bhe_s7_n),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .m_io     (m_io),
        .dt_r     (dt_r),
        .ctl_oe   (ctl_oe),
        .hlda     (hlda),
        .rsp_done (rsp_done)
    );

    assign rsp_rdata = ctx.rdata;
endmodule

// File: rtl/mbus_seq_chk.sv
`timescale 1ns/1ps
module mbus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_done,
    input logic ready,
    input logic hold,
    input logic hlda,
    input logic ad_oe,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic dt_r,
    input logic ctl_oe
);
    assert_ale_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_read_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!ad_oe && !dt_r));

    assert_write_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe && dt_r && rd_n));

    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_n || !wr_n) && !ready) |=> (!rd_n || !wr_n));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ale);

    assert_held_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ad_oe && !ctl_oe && !req_ready));

    assert_grant_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(hold));
endmodule

bind mbus_seq mbus_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .ready     (ready),
    .hold      (hold),
    .hlda      (hlda),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .dt_r      (dt_r),
    .ctl_oe    (ctl_oe)
);

// File: tb/mbus_seq_tb.sv
`timescale 1ns/1ps
module mbus_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b1;
    logic        req_hi = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic        hlda;
    logic [15:0] ad_o;
    logic        ad_oe;
    logic [15:0] ad_i = '0;
    logic [3:0]  ahs_o;
    logic        bhe_s7_n;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic        m_io;
    logic        dt_r;
    logic        ctl_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_mem(req_mem),
        .req_hi(req_hi), .req_seg(req_seg), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ready(ready), .hold(hold),
        .hlda(hlda), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .ahs_o(ahs_o),
        .bhe_s7_n(bhe_s7_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io),
        .dt_r(dt_r), .ctl_oe(ctl_oe)
    );

    function automatic logic [3:0] exp_status(input logic [1:0] seg);
        return {2'b00, seg};
    endfunction

    function automatic logic [3:0] exp_addr_hi(input logic [19:0] a);
        return a[19:16];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge with the block idle; returns at the
    // falling edge after T4.
    task automatic run_cycle(input logic [19:0] a, input logic w, input logic mem,
                             input logic hi, input logic [1:0] seg,
                             input logic [15:0] wd, input logic [15:0] rd,
                             input int nw, input bit hold_mid);
        req_addr = a; req_write = w; req_mem = mem; req_hi = hi;
        req_seg = seg; req_wdata = wd; req_valid = 1'b1;
        ad_i = ~rd;
        #1;
        chk("R8", "req_ready idle", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        // T1
        chk("R1", "ale T1", {31'd0, ale}, 32'd1);
        chk("R1", "ad_o addr", {16'd0, ad_o}, {16'd0, a[15:0]});
        chk("R1", "ad_oe T1", {31'd0, ad_oe}, 32'd1);
        chk("R1", "ahs addr", {28'd0, ahs_o}, {28'd0, exp_addr_hi(a)});
        chk("R1", "bhe T1", {31'd0, bhe_s7_n}, {31'd0, ~hi});
        chk("R5", "m_io T1", {31'd0, m_io}, {31'd0, mem});
        chk("R3", "strobes T1", {30'd0, rd_n, wr_n}, 32'd3);
        if (hold_mid) hold = 1'b1;
        @(negedge clk);
        // T2
        chk("R1", "ale T2", {31'd0, ale}, 32'd0);
        chk("R2", "status T2", {28'd0, ahs_o}, {28'd0, exp_status(seg)});
        chk("R2", "s7 T2", {31'd0, bhe_s7_n}, 32'd0);
        chk("R9", "no grant mid", {31'd0, hlda}, 32'd0);
        if (w) begin
            chk("R4", "wr_n T2", {30'd0, rd_n, wr_n}, 32'd2);
            chk("R4", "wdata T2", {15'd0, ad_oe, ad_o}, {15'd0, 1'b1, wd});
            chk("R4", "dt_r wr", {31'd0, dt_r}, 32'd1);
        end else begin
            chk("R3", "rd_n T2", {30'd0, rd_n, wr_n}, 32'd1);
            chk("R3", "float T2", {30'd0, ad_oe, dt_r}, 32'd0);
        end
        @(negedge clk);
        // T3
        chk("R2", "status T3", {28'd0, ahs_o}, {28'd0, exp_status(seg)});
        chk("R5", "m_io T3", {31'd0, m_io}, {31'd0, mem});
        ready = (nw == 0);
        ad_i  = (nw == 0) ? rd : ~rd;
        for (int k = 0; k < nw; k++) begin
            @(negedge clk);
            chk("R6", "wait strobe", {30'd0, rd_n, wr_n}, w ? 32'd2 : 32'd1);
            chk("R6", "no done in wait", {31'd0, rsp_done}, 32'd0);
            chk("R2", "status wait", {28'd0, ahs_o}, {28'd0, exp_status(seg)});
            ready = (k == nw - 1);
            ad_i  = (k == nw - 1) ? rd : ~rd;
        end
        @(negedge clk);
        // T4
        ready = 1'b1;
        ad_i = 16'h0;
        chk("R7", "done T4", {31'd0, rsp_done}, 32'd1);
        chk("R3", "strobes T4", {30'd0, rd_n, wr_n}, 32'd3);
        chk("R5", "m_io T4", {31'd0, m_io}, {31'd0, mem});
        if (!w) chk("R7", "rdata", {16'd0, rsp_rdata}, {16'd0, rd});
        else    chk("R4", "wdata T4", {16'd0, ad_o}, {16'd0, wd});
        @(negedge clk);
        chk("R7", "done clears", {31'd0, rsp_done}, 32'd0);
        if (hold_mid) begin
            chk("R9", "grant after T4", {31'd0, hlda}, 32'd1);
            chk("R9", "float held", {30'd0, ad_oe, ctl_oe}, 32'd0);
            hold = 1'b0;
            @(negedge clk);
            chk("R9", "release", {31'd0, hlda}, 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!finished) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R10", "reset hlda", {31'd0, hlda}, 32'd0);
        chk("R10", "reset strobes", {29'd0, ale, rd_n, wr_n}, 32'd3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "idle done", {31'd0, rsp_done}, 32'd0);
        chk("R10", "idle oe", {30'd0, ctl_oe, ad_oe}, 32'd2);
        chk("R10", "idle ready", {31'd0, req_ready}, 32'd1);

        // directed cycles
        run_cycle(20'hA5F3C, 1'b0, 1'b1, 1'b1, 2'd0, 16'h0, 16'hBEEF, 0, 0);
        run_cycle(20'h1234E, 1'b1, 1'b1, 1'b0, 2'd3, 16'hC0DE, 16'h0, 2, 0);
        run_cycle(20'hFFFFF, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0, 16'h5A5A, 3, 0);
        run_cycle(20'h00001, 1'b1, 1'b0, 1'b1, 2'd1, 16'hFFFF, 16'h0, 1, 0);

        // hold while idle; requests ignored while granted
        hold = 1'b1;
        req_valid = 1'b1;
        #1;
        chk("R9", "no accept under hold", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        chk("R9", "grant idle", {31'd0, hlda}, 32'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9", "held no ale", {31'd0, ale}, 32'd0);
            chk("R9", "held float", {31'd0, ctl_oe}, 32'd0);
        end
        hold = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9", "release idle", {31'd0, hlda}, 32'd0);
        chk("R9", "ctl drive back", {31'd0, ctl_oe}, 32'd1);

        // hold raised during a cycle
        run_cycle(20'h7E001, 1'b0, 1'b1, 1'b0, 2'd3, 16'h0, 16'h1357, 2, 1);

        // random cycles
        for (int n = 0; n < 40; n++) begin
            logic [31:0] r;
            r = $urandom;
            run_cycle($urandom % 32'h100000, r[0], r[1], r[2], r[4:3],
                      $urandom % 32'h10000, $urandom % 32'h10000,
                      int'(r[7:5] % 3'd4), r[9:8] == 2'b11);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule